// File: doc/BRIEF.md
# Main-Link Training Sequencer

This block runs the source side of the two-phase training handshake that brings up a serial display main link. It first establishes clock recovery and then channel equalization. It sets the transmitter's pattern select, its scrambler bypass and its per-lane drive levels. It reaches the sink's configuration registers through a small command/response port that stands in for the sideband channel. Each command carries an operation code and a 32-bit payload, and each read returns a packed status word. The waits between status polls are programmable cycle counts.

A host pulses `start`. The block then drives the whole sequence on its own and ends with a one-cycle `done` pulse and a 2-bit result code. Which lanes are active, the link rate class and whether the sink supports pattern 3 are all sampled when `start` is accepted. A `start` that arrives while a run is in progress is ignored.

The command port follows valid/ready rules. `cmd_valid` stays high, and `cmd_op` and `cmd_data` stay unchanged, until the cycle in which `cmd_ready` is high. Only one command is outstanding at a time. `rsp_ready` is high only while the block waits for the answer to a command it has already handed over, and a response is consumed in a cycle where both `rsp_valid` and `rsp_ready` are high. The sink side may stall either channel for any number of cycles.

Top module: `lt_train_seq`

## Requirements
- R1: On an accepted `start`, the swing and pre-emphasis levels return to 0. The first command issued is a coding write (op 0) with payload 1. Command op codes are: 0 coding write, 1 pattern write, 2 drive-level write, 3 status read.
- R2: Phase one sets `tx_pattern`=1 and `tx_scramble_off`=1, then writes pattern byte 0x21 to the sink. In a pattern byte, bits [3:0] hold the pattern number and bit 5 disables scrambling. Phase one succeeds when clock-recovery lock is set on every active lane.
- R3: In phase one, when lock is missing and the swing is already at level 3, the run ends with result 1 (retryable).
- R4: In phase one, a try counter rises only when the swing is the same as at the previous evaluation, and it clears when the swing changes. Reaching 5 tries ends the run with result 2 (failure).
- R5: Phase two uses pattern 3 (byte 0x23) when `tps3_ok` was set at start, and pattern 2 (byte 0x22) otherwise. Scrambling is disabled in both cases, and `tx_pattern` matches the pattern used.
- R6: In phase two, losing lock on any active lane gives result 2. Equalization on every active lane together with the align bit gives result 0. When neither happens, the seventh evaluation gives result 3 (lane reduction).
- R7: A drive-level write carries the same byte in all four byte lanes. Each byte is swing in [1:0], pre-emphasis in [4:3], bit 2 set when swing is 3, and bit 5 set when pre-emphasis is 3. The byte always equals the current `tx_swing`/`tx_preemph`.
- R8: New levels are the maximum swing and pre-emphasis requested over the active lanes. Lane i is active when i < `lane_cnt`, and inactive lanes are ignored entirely. The status word holds lock in [3:0], equalization in [7:4], align in [8], updated in [9], swing requests in [17:10] and pre-emphasis requests in [25:18], 2 bits per lane with lane i lowest first. `tx_high_rate` is set when `rate_code` is 2 or 3.
- R9: Every run, passed or failed, ends in the same way. `tx_pattern` and `tx_scramble_off` are cleared, pattern byte 0 is written to the sink as the last command, and the equalization wait runs. Then `done` pulses for one cycle with `result` (0 pass, 1 retryable, 2 failure, 3 lane reduction).
- R10: `abort` is checked once per loop iteration, and when it is high the run ends with result 2.
- R11: A status read is repeated while the updated bit is set, up to 99 reads, and the last read is then evaluated. A response with `rsp_ok`=0 ends the run with result 2, except during the final clearing write.
- R12: A command stays valid and unchanged until it is accepted, and no new command is issued while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a training run (ignored while busy) |
| abort | input | 1 | Terminate the run at the next loop check |
| lane_cnt | input | 3 | Active lane count: 1, 2 or 4 |
| rate_code | input | 2 | Link rate class; 2 and 3 are the high rates |
| tps3_ok | input | 1 | Sink supports pattern 3 |
| cr_wait | input | WAIT_W | Cycles waited before each phase-one poll |
| eq_wait | input | WAIT_W | Cycles waited before each phase-two poll and at the end |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_op | output | 2 | Command operation code |
| cmd_data | output | 32 | Command payload |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Block can take a response |
| rsp_ok | input | 1 | Transaction completed without error |
| rsp_data | input | 26 | Packed sink status word |
| tx_pattern | output | 2 | Transmitter pattern select (0 none) |
| tx_scramble_off | output | 1 | Transmitter scrambler bypass |
| tx_swing | output | 2 | Transmitter swing level |
| tx_preemph | output | 2 | Transmitter pre-emphasis level |
| tx_high_rate | output | 1 | Transmitter high-rate drive settings |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | Outcome of the run, valid with done |

## Verification
The embedded properties check the handshake rules of the command channel on every cycle. They also check that every drive word sent matches the transmitter levels, that the transmitter runs pattern 1 whenever the sink is given pattern 1, that `done` is a single cycle with the pattern already cleared, and that a retryable outcome happens only at maximum swing. The try-counting policies cannot be seen in any single cycle, so only the bench's scenarios show them. These are the five same-swing tries of phase one, the counter reset when the swing moves, and the seventh-evaluation lane reduction of phase two. The same holds for the updated-flag re-reads, abort, sideband errors, lane masking and the pattern-3 versus pattern-2 choice, which the bench shows through the number of status reads, the command log and the result code.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int LANES = 4;
  localparam int ST_W  = 26;
  localparam logic [1:0] OP_CODING  = 2'd0;
  localparam logic [1:0] OP_PATTERN = 2'd1;
  localparam logic [1:0] OP_DRIVE   = 2'd2;
  localparam logic [1:0] OP_STATUS  = 2'd3;
  localparam logic [1:0] RES_PASS  = 2'd0;
  localparam logic [1:0] RES_RETRY = 2'd1;
  localparam logic [1:0] RES_FAIL  = 2'd2;
  localparam logic [1:0] RES_LANES = 2'd3;

  function automatic logic [31:0] drive_word(input logic [1:0] sw, input logic [1:0] pe);
    logic [7:0] b;
    b = {2'b00, (pe == 2'd3), pe, (sw == 2'd3), sw};
    return {4{b}};
  endfunction
endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] count,
  output logic         expired
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  assign expired = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= count;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lt_status_judge.sv
module lt_status_judge
  import lt_pkg::*;
(
  input  logic [ST_W-1:0] status,
  input  logic [2:0]      lane_cnt,
  output logic            cr_all,
  output logic            eq_all,
  output logic            updated,
  output logic [1:0]      req_sw,
  output logic [1:0]      req_pe
);
  logic [LANES-1:0] cr_m, eq_m;
  logic [1:0] sw_l [LANES];
  logic [1:0] pe_l [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic act;
    assign act     = (3'(i) < lane_cnt);
    assign cr_m[i] = !act || status[i];
    assign eq_m[i] = !act || status[4 + i];
    assign sw_l[i] = act ? status[10 + 2*i +: 2] : 2'd0;
    assign pe_l[i] = act ? status[18 + 2*i +: 2] : 2'd0;
  end

  assign cr_all  = &cr_m;
  assign eq_all  = (&eq_m) && status[8];
  assign updated = status[9];

  always_comb begin
    req_sw = 2'd0;
    req_pe = 2'd0;
    for (int i = 0; i < LANES; i++) begin
      if (sw_l[i] > req_sw) req_sw = sw_l[i];
      if (pe_l[i] > req_pe) req_pe = pe_l[i];
    end
  end
endmodule

// File: rtl/lt_train_seq.sv
module lt_train_seq
  import lt_pkg::*;
#(
  parameter int WAIT_W     = 16,
  parameter int P1_TRIES   = 5,
  parameter int P2_TRIES   = 5,
  parameter int READ_TRIES = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [2:0]        lane_cnt,
  input  logic [1:0]        rate_code,
  input  logic              tps3_ok,
  input  logic [WAIT_W-1:0] cr_wait,
  input  logic [WAIT_W-1:0] eq_wait,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [31:0]       cmd_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_ok,
  input  logic [25:0]       rsp_data,
  output logic [1:0]        tx_pattern,
  output logic              tx_scramble_off,
  output logic [1:0]        tx_swing,
  output logic [1:0]        tx_preemph,
  output logic              tx_high_rate,
  output logic              done,
  output logic [1:0]        result
);
  localparam int TW = $clog2(P1_TRIES + P2_TRIES + 2);
  localparam int RW = $clog2(READ_TRIES + 1);
  localparam logic [TW-1:0] P1_LAST = TW'(P1_TRIES - 1);
  localparam logic [TW-1:0] P2_LIM  = TW'(P2_TRIES);
  localparam logic [RW-1:0] RD_LIM  = RW'(READ_TRIES);

  typedef enum logic [3:0] {
    S_IDLE, S_AUX, S_P1PAT, S_P1DRV, S_P1INI, S_LOOP, S_WAIT, S_EVAL,
    S_P2DRV, S_P2PAT, S_CLR, S_CLRW, S_CLRT
  } st_e;

  st_e st_q, ret_q;
  logic [2:0]      lanes_q;
  logic [1:0]      rate_q, sw_q, pe_q, old_sw_q, res_q;
  logic            tps3_q, phase2_q, clearing_q;
  logic [TW-1:0]   tries_q;
  logic [RW-1:0]   reads_q;
  logic [ST_W-1:0] status_q;
  logic            cr_all, eq_all, upd;
  logic [1:0]      req_sw, req_pe;
  logic            tmr_load, tmr_done;
  logic [WAIT_W-1:0] tmr_val;

  lt_status_judge judge_i (
    .status(status_q), .lane_cnt(lanes_q), .cr_all(cr_all), .eq_all(eq_all),
    .updated(upd), .req_sw(req_sw), .req_pe(req_pe)
  );

  assign tmr_load = (st_q == S_LOOP && !abort) || (st_q == S_CLRW);
  assign tmr_val  = (phase2_q || clearing_q) ? eq_wait : cr_wait;

  lt_wait_timer #(.W(WAIT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .count(tmr_val), .expired(tmr_done)
  );

  assign rsp_ready  = (st_q == S_AUX) && !cmd_valid;
  assign tx_swing   = sw_q;
  assign tx_preemph = pe_q;

  task automatic issue(input logic [1:0] op, input logic [31:0] d, input st_e nx);
    cmd_valid <= 1'b1;
    cmd_op    <= op;
    cmd_data  <= d;
    ret_q     <= nx;
    st_q      <= S_AUX;
  endtask

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; ret_q <= S_IDLE;
      cmd_valid <= 1'b0; cmd_op <= 2'd0; cmd_data <= '0;
      lanes_q <= 3'd0; rate_q <= 2'd0; tps3_q <= 1'b0;
      sw_q <= 2'd0; pe_q <= 2'd0; old_sw_q <= 2'd0; res_q <= RES_PASS;
      phase2_q <= 1'b0; clearing_q <= 1'b0; tries_q <= '0; reads_q <= '0;
      status_q <= '0; tx_pattern <= 2'd0; tx_scramble_off <= 1'b0;
      tx_high_rate <= 1'b0; done <= 1'b0; result <= RES_PASS;
    end else begin
      done <= 1'b0;
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          lanes_q <= lane_cnt; rate_q <= rate_code; tps3_q <= tps3_ok;
          sw_q <= 2'd0; pe_q <= 2'd0; phase2_q <= 1'b0; clearing_q <= 1'b0;
          issue(OP_CODING, 32'd1, S_P1PAT);
        end
        S_AUX: if (rsp_valid && rsp_ready) begin
          status_q <= rsp_data;
          if (!rsp_ok && !clearing_q) begin res_q <= RES_FAIL; st_q <= S_CLR; end
          else st_q <= ret_q;
        end
        S_P1PAT: begin
          tx_pattern <= 2'd1; tx_scramble_off <= 1'b1;
          issue(OP_PATTERN, 32'h21, S_P1DRV);
        end
        S_P1DRV: begin
          tx_high_rate <= rate_q[1];
          issue(OP_DRIVE, drive_word(sw_q, pe_q), S_P1INI);
        end
        S_P1INI: begin tries_q <= '0; old_sw_q <= sw_q; st_q <= S_LOOP; end
        S_LOOP: begin
          if (abort) begin res_q <= RES_FAIL; st_q <= S_CLR; end
          else st_q <= S_WAIT;
        end
        S_WAIT: if (tmr_done) begin
          reads_q <= RW'(1);
          issue(OP_STATUS, 32'd0, S_EVAL);
        end
        S_EVAL: begin
          if (upd && reads_q < RD_LIM) begin
            reads_q <= reads_q + 1'b1;
            issue(OP_STATUS, 32'd0, S_EVAL);
          end else if (!phase2_q) begin
            if (cr_all) begin phase2_q <= 1'b1; tries_q <= '0; st_q <= S_P2DRV; end
            else if (sw_q == 2'd3) begin res_q <= RES_RETRY; st_q <= S_CLR; end
            else if (old_sw_q == sw_q && tries_q >= P1_LAST) begin res_q <= RES_FAIL; st_q <= S_CLR; end
            else begin
              if (old_sw_q == sw_q) tries_q <= tries_q + 1'b1;
              else begin tries_q <= '0; old_sw_q <= sw_q; end
              sw_q <= req_sw; pe_q <= req_pe; tx_high_rate <= rate_q[1];
              issue(OP_DRIVE, drive_word(req_sw, req_pe), S_LOOP);
            end
          end else begin
            if (!cr_all) begin res_q <= RES_FAIL; st_q <= S_CLR; end
            else if (eq_all) begin res_q <= RES_PASS; st_q <= S_CLR; end
            else if (tries_q > P2_LIM) begin res_q <= RES_LANES; st_q <= S_CLR; end
            else begin
              tries_q <= tries_q + 1'b1;
              sw_q <= req_sw; pe_q <= req_pe; tx_high_rate <= rate_q[1];
              issue(OP_DRIVE, drive_word(req_sw, req_pe), S_LOOP);
            end
          end
        end
        S_P2DRV: begin
          tx_high_rate <= rate_q[1];
          issue(OP_DRIVE, drive_word(sw_q, pe_q), S_P2PAT);
        end
        S_P2PAT: begin
          tx_pattern <= tps3_q ? 2'd3 : 2'd2; tx_scramble_off <= 1'b1;
          issue(OP_PATTERN, tps3_q ? 32'h23 : 32'h22, S_LOOP);
        end
        S_CLR: begin
          tx_pattern <= 2'd0; tx_scramble_off <= 1'b0; clearing_q <= 1'b1;
          issue(OP_PATTERN, 32'd0, S_CLRW);
        end
        S_CLRW: st_q <= S_CLRT;
        S_CLRT: if (tmr_done) begin done <= 1'b1; result <= res_q; st_q <= S_IDLE; end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R12
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data));
  // R12
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rsp_ready);
  // R7
  drive_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_DRIVE |-> cmd_data[1:0] == tx_swing && cmd_data[4:3] == tx_preemph);
  // R2
  p1_tx_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_PATTERN && cmd_data[3:0] == 4'd1 |-> tx_pattern == 2'd1 && tx_scramble_off);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tx_pattern == 2'd0 && !tx_scramble_off);
  // R3
  retry_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == RES_RETRY |-> tx_swing == 2'd3);
endmodule

// File: tb/lt_train_seq_tb_top.sv
module lt_train_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, tps3_ok = 1'b0;
  logic [2:0] lane_cnt = 3'd4;
  logic [1:0] rate_code = 2'd0;
  logic [15:0] cr_wait = 16'd3, eq_wait = 16'd5;
  logic cmd_valid, cmd_ready = 1'b0, rsp_ready, rsp_valid = 1'b0, rsp_ok = 1'b1;
  logic [1:0] cmd_op;
  logic [31:0] cmd_data;
  logic [25:0] rsp_data = '0;
  logic [1:0] tx_pattern, tx_swing, tx_preemph, result;
  logic tx_scramble_off, tx_high_rate, done;

  always #10 clk = ~clk;

  lt_train_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .lane_cnt(lane_cnt),
    .rate_code(rate_code), .tps3_ok(tps3_ok), .cr_wait(cr_wait), .eq_wait(eq_wait),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
    .tx_pattern(tx_pattern), .tx_scramble_off(tx_scramble_off), .tx_swing(tx_swing),
    .tx_preemph(tx_preemph), .tx_high_rate(tx_high_rate), .done(done), .result(result)
  );

  int n_cmp = 0, n_bad = 0;
  // sink scenario
  int cr_after, eq_after, drop_at, upd_left, err_idx, abort_at, sink_lanes;
  bit ramp, bp_on = 1'b0;
  logic [1:0] sw_req [4];
  logic [1:0] pe_req0;
  // sink observations
  int ncmd, nreads, p1_iter, p2_iter, lat_cnt = 0;
  logic [3:0] cur_pat;
  logic [31:0] first_data, p1_pat, p2_pat, last_data, last_drv;
  logic [1:0] first_op, last_op;
  logic pend_ok; logic [25:0] pend_data;
  bit rsp_take = 0, got_done = 0;
  logic [1:0] got_res;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [25:0] mk_status(input bit ph2, input int iter, input bit upd);
    logic [3:0] m; logic [3:0] cr, eq; logic [7:0] sw, pe; logic al;
    m = 4'((1 << sink_lanes) - 1);
    if (!ph2) begin cr = (iter >= cr_after) ? m : 4'h0; eq = 4'h0; al = 1'b0; end
    else begin
      cr = (drop_at != 0 && iter >= drop_at) ? 4'h0 : m;
      eq = (iter >= eq_after) ? m : 4'h0; al = (iter >= eq_after);
    end
    for (int i = 0; i < 4; i++) sw[2*i +: 2] = sw_req[i];
    if (ramp) sw[1:0] = (iter >= 3) ? 2'd3 : 2'(iter);
    pe = {6'd0, pe_req0};
    return {pe, sw, upd, al, eq, cr};
  endfunction

  // sink model and done monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_take) begin rsp_valid = 1'b0; rsp_take = 0; end
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin rsp_valid = 1'b1; rsp_ok = pend_ok; rsp_data = pend_data; end
      end
      cmd_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
      if (cmd_valid && cmd_ready) begin
        ncmd++;
        if (ncmd == 1) begin first_op = cmd_op; first_data = cmd_data; end
        last_op = cmd_op; last_data = cmd_data; pend_data = '0;
        if (cmd_op == 2'd1) begin
          cur_pat = cmd_data[3:0];
          if (cmd_data[3:0] == 4'd1) p1_pat = cmd_data;
          if (cmd_data[3:0] >= 4'd2) p2_pat = cmd_data;
        end
        if (cmd_op == 2'd2) last_drv = cmd_data;
        if (cmd_op == 2'd3) begin
          bit u; int it; bit ph2;
          nreads++;
          u = (upd_left > 0); if (u) upd_left--;
          ph2 = (cur_pat >= 4'd2);
          it = (ph2 ? p2_iter : p1_iter) + 1;
          pend_data = mk_status(ph2, it, u);
          if (!u) begin if (ph2) p2_iter++; else p1_iter++; end
        end
        pend_ok = (ncmd != err_idx);
        lat_cnt = 1 + int'($urandom % 3);
      end
      rsp_take = rsp_valid && rsp_ready;
      if (abort_at > 0 && p1_iter >= abort_at) abort = 1'b1;
      if (done) begin got_done = 1; got_res = result; end
    end
  end

  task automatic defaults();
    cr_after = 1; eq_after = 1; drop_at = 0; upd_left = 0; err_idx = 0; abort_at = 0;
    sink_lanes = 4; ramp = 0; pe_req0 = 2'd0;
    for (int i = 0; i < 4; i++) sw_req[i] = 2'd0;
  endtask

  task automatic run(input logic [2:0] lc, input logic [1:0] rc, input logic t3);
    @(negedge clk);
    ncmd = 0; nreads = 0; p1_iter = 0; p2_iter = 0; got_done = 0; abort = 1'b0;
    cur_pat = 4'd0; p1_pat = '0; p2_pat = '0; last_drv = '0;
    lane_cnt = lc; rate_code = rc; tps3_ok = t3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 30000 && !got_done; k++) @(negedge clk);
    if (!got_done) check("watchdog run", 32'd0, 32'd1);
    abort = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    check("R9 reset done", {31'd0, done}, 32'd0);
    check("R12 reset cmd_valid", {31'd0, cmd_valid}, 32'd0);
    check("R9 reset tx_pattern", {30'd0, tx_pattern}, 32'd0);
    rst_n = 1'b1;

    // basic pass, pattern 3
    defaults(); run(3'd4, 2'd0, 1'b1);
    check("R6 pass result", {30'd0, got_res}, 32'd0);
    check("R1 first op", {30'd0, first_op}, 32'd0);
    check("R1 first data", first_data, 32'd1);
    check("R2 p1 pattern byte", p1_pat, 32'h21);
    check("R5 tps3 byte", p2_pat, 32'h23);
    check("R9 last op", {30'd0, last_op}, 32'd1);
    check("R9 last data", last_data, 32'd0);
    check("R8 low rate", {31'd0, tx_high_rate}, 32'd0);
    check("R11 read count", nreads, 2);

    bp_on = 1'b1;
    // pattern 2
    defaults(); run(3'd4, 2'd1, 1'b0);
    check("R5 tps2 result", {30'd0, got_res}, 32'd0);
    check("R5 tps2 byte", p2_pat, 32'h22);

    // retry at max swing
    defaults(); cr_after = 99; ramp = 1; pe_req0 = 2'd3; run(3'd4, 2'd3, 1'b1);
    check("R3 retry result", {30'd0, got_res}, 32'd1);
    check("R3 retry reads", nreads, 4);
    check("R7 max drive word", last_drv, 32'h3F3F3F3F);
    check("R3 swing at max", {30'd0, tx_swing}, 32'd3);
    check("R7 preemph", {30'd0, tx_preemph}, 32'd3);
    check("R8 high rate", {31'd0, tx_high_rate}, 32'd1);

    // timeout at same swing
    defaults(); cr_after = 99; run(3'd4, 2'd0, 1'b1);
    check("R4 timeout result", {30'd0, got_res}, 32'd2);
    check("R4 timeout reads", nreads, 5);

    // swing changes once, counter restarts
    defaults(); cr_after = 99; sw_req[0] = 2'd1; run(3'd4, 2'd0, 1'b1);
    check("R4 reset-on-change result", {30'd0, got_res}, 32'd2);
    check("R4 reset-on-change reads", nreads, 7);

    // CR lost in phase two
    defaults(); drop_at = 1; run(3'd4, 2'd0, 1'b1);
    check("R6 cr loss result", {30'd0, got_res}, 32'd2);

    // lane reduction
    defaults(); eq_after = 99; run(3'd4, 2'd0, 1'b1);
    check("R6 lane reduce result", {30'd0, got_res}, 32'd3);
    check("R6 lane reduce reads", nreads, 8);

    // two lanes, inactive lanes ignored, max over active
    defaults(); sink_lanes = 2; cr_after = 2; sw_req[1] = 2'd2; sw_req[3] = 2'd3;
    run(3'd2, 2'd2, 1'b1);
    check("R8 masked result", {30'd0, got_res}, 32'd0);
    check("R8 max active swing", {30'd0, tx_swing}, 32'd2);
    check("R7 drive word", last_drv, 32'h02020202);
    check("R8 rate 2 high", {31'd0, tx_high_rate}, 32'd1);

    // abort
    defaults(); cr_after = 99; abort_at = 2; run(3'd4, 2'd0, 1'b1);
    check("R10 abort result", {30'd0, got_res}, 32'd2);
    check("R10 abort reads", nreads, 2);
    check("R9 abort clear", last_data, 32'd0);

    // sideband error on drive write
    defaults(); err_idx = 3; run(3'd4, 2'd0, 1'b1);
    check("R11 aux error result", {30'd0, got_res}, 32'd2);
    check("R11 aux error cmds", ncmd, 4);
    check("R9 aux error last data", last_data, 32'd0);

    // updated flag re-reads
    defaults(); upd_left = 3; run(3'd4, 2'd0, 1'b1);
    check("R11 updated result", {30'd0, got_res}, 32'd0);
    check("R11 updated reads", nreads, 5);
    defaults(); upd_left = 100000; run(3'd1, 2'd0, 1'b1);
    check("R11 read cap result", {30'd0, got_res}, 32'd0);
    check("R11 read cap reads", nreads, 198);

    // constrained random
    void'($urandom(32'd20250611));
    for (int n = 0; n < 20; n++) begin
      int lc, er, ep; logic [1:0] res_e; logic t3;
      defaults();
      cr_after = 1 + int'($urandom % 6); eq_after = 1 + int'($urandom % 8);
      pe_req0 = 2'($urandom % 4); t3 = 1'($urandom % 2);
      lc = (n % 3 == 0) ? 1 : ((n % 3 == 1) ? 2 : 4); sink_lanes = lc;
      if (cr_after > 5) begin res_e = 2'd2; er = 5; end
      else if (eq_after <= 7) begin res_e = 2'd0; er = cr_after + eq_after; end
      else begin res_e = 2'd3; er = cr_after + 7; end
      ep = t3 ? 32'h23 : 32'h22;
      run(3'(lc), 2'($urandom % 4), t3);
      check("R6 random result", {30'd0, got_res}, {30'd0, res_e});
      check("R4 random reads", nreads, er);
      check("R9 random last data", last_data, 32'd0);
      if (cr_after <= 5) check("R5 random pattern", p2_pat, ep);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule